// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from table memory. The processor side offers one address at a time. The block fetches the first-level descriptor, and the low two bits of that descriptor decide what happens next. A section descriptor maps a 1 MB region at once. A link descriptor points to a second-level table of 256 entries. A fault descriptor ends the walk. When a second level is read, its descriptor maps either a 64 KB large page or a 4 KB small page, or it faults.

Each table read goes through a word-read port. The request side uses a valid/ready handshake. The returned word arrives on a separate valid strobe. A section walk costs one read and a page walk costs two. Each translation ends with a single-cycle response. The response carries the physical address, or a fault flag with the level at which the walk stopped, and always echoes the virtual address.

Top module: `va_xlate_walker`

## Requirements
- R1: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the cycle after acceptance until the response has been issued, so a request held during that time is not taken until the walk ends.
- R2: The first read address is `{ttb_i[31:14], va[31:20], 2'b00}`. Bits 13:0 of `ttb_i` have no effect.
- R3: A first-level descriptor with bits[1:0] = 2'b10 is a section. The response gives PA = `{desc[31:20], va[19:0]}` with no fault, after exactly one table read.
- R4: A first-level descriptor with bits[1:0] = 2'b01 is a link. A second read is issued at `{desc[31:10], va[19:12], 2'b00}`.
- R5: A second-level descriptor with bits[1:0] = 2'b01 is a large page, giving PA = `{desc[31:16], va[15:0]}`.
- R6: A second-level descriptor with bits[1:0] = 2'b10 is a small page, giving PA = `{desc[31:12], va[11:0]}`.
- R7: A first-level descriptor with bits[1:0] = 2'b00 or 2'b11 gives a fault response with `rsp_level_o` = 0 and `rsp_pa_o` = 0, after one read.
- R8: A second-level descriptor with bits[1:0] = 2'b00 or 2'b11 gives a fault response with `rsp_level_o` = 1 and `rsp_pa_o` = 0, after two reads.
- R9: `mem_req_valid_o` stays high, with `mem_addr_o` unchanged, until `mem_req_ready_i` accepts it. One read is made per table level, and never more than two per walk.
- R10: `rsp_valid_o` is high for exactly one cycle per translation, and `rsp_va_o` then equals the accepted virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | First-level table base, 16 KB aligned |
| req_valid_i | input | 1 | Translation request valid |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Block idle, request can be taken |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Walk ended on an invalid descriptor |
| rsp_level_o | output | 1 | Fault level: 0 first, 1 second |
| rsp_va_o | output | 32 | Echo of the translated virtual address |
| rsp_pa_o | output | 32 | Physical address, zero on fault |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Table memory accepts the read |
| mem_addr_o | output | 32 | Word address of the descriptor |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Descriptor word |

## Verification
The assertions assume that table memory raises `mem_rsp_valid_i` exactly once per accepted read, and only while the walker is waiting for that word. They also assume the returned word is never early, meaning it never arrives in the acceptance cycle itself. The bench memory model follows these rules: it answers each accepted read on the following cycle, and it deasserts the strobe right after. The vector set is run twice, once with memory always ready and once with `mem_req_ready_i` toggling every cycle, so that held requests are exercised. A further run keeps `req_valid_i` high while the block is busy.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int AW        = 32;
  localparam int SECT_SH   = 20;  // section offset width
  localparam int LARGE_SH  = 16;  // large page offset width
  localparam int SMALL_SH  = 12;  // small page offset width
  localparam int TTB_SH    = 14;  // base register alignment
  localparam int L2BASE_SH = 10;  // second-level table alignment
  localparam int L1_IDX_W  = AW - SECT_SH;
  localparam int L2_IDX_W  = SECT_SH - SMALL_SH;

  typedef enum logic [1:0] {
    K_FAULT = 2'b00,
    K_LINK  = 2'b01,
    K_BLOCK = 2'b10,
    K_RSVD  = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } state_e;
endpackage

// File: rtl/xlate_l1_dec.sv
module xlate_l1_dec
  import xlate_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          sect_o,
  output logic          link_o,
  output logic [AW-1:0] pa_o,
  output logic [AW-1:0] l2_addr_o
);
  kind_e kind;
  logic  unused_bits;

  assign kind        = kind_e'(desc_i[1:0]);
  assign sect_o      = (kind == K_BLOCK);
  assign link_o      = (kind == K_LINK);
  assign pa_o        = {desc_i[AW-1:SECT_SH], va_i[SECT_SH-1:0]};
  assign l2_addr_o   = {desc_i[AW-1:L2BASE_SH], va_i[SECT_SH-1:SMALL_SH], 2'b00};
  assign unused_bits = ^{desc_i[L2BASE_SH-1:2], va_i[AW-1:SECT_SH], va_i[SMALL_SH-1:0]};
endmodule

// File: rtl/xlate_l2_dec.sv
module xlate_l2_dec
  import xlate_pkg::*;
(
  input  logic [AW-1:0]       desc_i,
  input  logic [LARGE_SH-1:0] va_lo_i,
  output logic                ok_o,
  output logic [AW-1:0]       pa_o
);
  kind_e kind;
  logic  unused_bits;

  assign kind = kind_e'(desc_i[1:0]);
  assign ok_o = (kind == K_LINK) || (kind == K_BLOCK);

  always_comb begin
    unique case (kind)
      K_LINK:  pa_o = {desc_i[AW-1:LARGE_SH], va_lo_i};
      K_BLOCK: pa_o = {desc_i[AW-1:SMALL_SH], va_lo_i[SMALL_SH-1:0]};
      default: pa_o = '0;
    endcase
  end

  assign unused_bits = ^desc_i[SMALL_SH-1:2];
endmodule

// File: rtl/va_xlate_walker.sv
module va_xlate_walker
  import xlate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   ttb_i,
  input  logic          req_valid_i,
  input  logic [31:0]   req_va_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic          rsp_fault_o,
  output logic          rsp_level_o,
  output logic [31:0]   rsp_va_o,
  output logic [31:0]   rsp_pa_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i
);
  state_e        state_q;
  logic [AW-1:0] va_q, addr_q, pa_q;
  logic          fault_q, level_q;
  logic [1:0]    rd_cnt_q;

  logic          l1_sect, l1_link, l2_ok;
  logic [AW-1:0] l1_pa, l1_next, l2_pa, l1_addr;
  logic          unused_ttb;

  xlate_l1_dec i_l1_dec (
    .desc_i    (mem_rsp_data_i),
    .va_i      (va_q),
    .sect_o    (l1_sect),
    .link_o    (l1_link),
    .pa_o      (l1_pa),
    .l2_addr_o (l1_next)
  );

  xlate_l2_dec i_l2_dec (
    .desc_i  (mem_rsp_data_i),
    .va_lo_i (va_q[LARGE_SH-1:0]),
    .ok_o    (l2_ok),
    .pa_o    (l2_pa)
  );

  assign l1_addr    = {ttb_i[AW-1:TTB_SH], req_va_i[AW-1:SECT_SH], 2'b00};
  assign unused_ttb = ^ttb_i[TTB_SH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      addr_q   <= '0;
      pa_q     <= '0;
      fault_q  <= 1'b0;
      level_q  <= 1'b0;
      rd_cnt_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q     <= req_va_i;
          addr_q   <= l1_addr;
          rd_cnt_q <= '0;
          state_q  <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready_i) begin
          rd_cnt_q <= rd_cnt_q + 2'd1;
          state_q  <= S_L1_WAIT;
        end
        S_L1_WAIT: if (mem_rsp_valid_i) begin
          level_q <= 1'b0;
          if (l1_sect) begin
            pa_q    <= l1_pa;
            fault_q <= 1'b0;
            state_q <= S_DONE;
          end else if (l1_link) begin
            addr_q  <= l1_next;
            state_q <= S_L2_REQ;
          end else begin
            pa_q    <= '0;
            fault_q <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_L2_REQ: if (mem_req_ready_i) begin
          rd_cnt_q <= rd_cnt_q + 2'd1;
          state_q  <= S_L2_WAIT;
        end
        S_L2_WAIT: if (mem_rsp_valid_i) begin
          fault_q <= !l2_ok;
          level_q <= !l2_ok;
          pa_q    <= l2_ok ? l2_pa : '0;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign mem_addr_o      = addr_q;
  assign rsp_valid_o     = (state_q == S_DONE);
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = level_q;
  assign rsp_va_o        = va_q;
  assign rsp_pa_o        = pa_q;

  // R1: busy right after a request is taken
  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R9: a stalled read holds valid and address
  assert_hold_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  // R9: at most two reads per walk
  assert_read_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= 2'd2);

  // R7: a first-level fault costs a single read
  assert_l1_fault_one_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o && !rsp_level_o |-> rd_cnt_q == 2'd1);

  // R10: response is a one-cycle pulse
  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/test_va_xlate_walker.sv
`timescale 1ns/1ps
module test_va_xlate_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ttb_i = 32'h0010_3FFF;  // junk low bits, R2
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_fault_o, rsp_level_o;
  logic [31:0] rsp_va_o, rsp_pa_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b1;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  int checks = 0, fails = 0;
  bit done = 0, stall = 0, pend = 0;
  int cyc = 0, rd_n = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] rd_addr [2];

  always #2.5 clk_i = ~clk_i;

  va_xlate_walker i_va_xlate_walker (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h0010_0004: return 32'hABC5_5552;  // section
      32'h0010_0008: return 32'h0020_07FD;  // link to 0x0020_0400
      32'h0010_000C: return 32'h0000_0000;  // fault
      32'h0010_0010: return 32'h0000_0013;  // type 11
      32'h0010_3FFC: return 32'hFFF0_0002;  // section, last index
      32'h0020_0414: return 32'h1234_ABC1;  // large page
      32'h0020_0418: return 32'h5678_9FFE;  // small page
      32'h0020_041C: return 32'h0000_0000;  // fault
      32'h0020_0420: return 32'h0000_0FF3;  // type 11
      default:       return 32'h0000_0000;
    endcase
  endfunction

  // table memory: one-cycle read latency
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem_word(pend_addr);
        pend = 0;
      end
      mem_req_ready_i = !(stall && cyc[0]);
      if (mem_req_valid_o && mem_req_ready_i) begin
        pend = 1;
        pend_addr = mem_addr_o;
        if (rd_n < 2) rd_addr[rd_n] = mem_addr_o;
        rd_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // {va, fault, level, reads, pa}
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0012_3456, 1'b0, 1'b0, 2'd1, 32'hABC2_3456},
    {32'h001F_FFFF, 1'b0, 1'b0, 2'd1, 32'hABCF_FFFF},
    {32'hFFFF_FFFF, 1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF},
    {32'h0020_5ABC, 1'b0, 1'b0, 2'd2, 32'h1234_5ABC},
    {32'h0020_6DEF, 1'b0, 1'b0, 2'd2, 32'h5678_9DEF},
    {32'h0020_7000, 1'b1, 1'b1, 2'd2, 32'h0000_0000},
    {32'h0020_8123, 1'b1, 1'b1, 2'd2, 32'h0000_0000},
    {32'h0030_0000, 1'b1, 1'b0, 2'd1, 32'h0000_0000},
    {32'h0041_1111, 1'b1, 1'b0, 2'd1, 32'h0000_0000}
  };

  task automatic issue(input logic [31:0] va);
    rd_n = 0;
    req_valid_i = 1'b1;
    req_va_i = va;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic run_vec(input logic [67:0] v);
    logic [31:0] va, pa;
    logic        flt, lvl;
    logic [1:0]  nrd;
    string       tag;
    {va, flt, lvl, nrd, pa} = v;
    if (flt) tag = lvl ? "R8" : "R7";
    else if (nrd == 2'd1) tag = "R3";
    else tag = (va[19:12] == 8'h05) ? "R5" : "R6";
    issue(va);
    check(!req_ready_o, "R1 busy", {31'b0, req_ready_o}, 32'h0);
    while (!rsp_valid_o) @(negedge clk_i);
    check(rsp_fault_o == flt, {tag, " fault"}, {31'b0, rsp_fault_o}, {31'b0, flt});
    if (flt) check(rsp_level_o == lvl, {tag, " level"}, {31'b0, rsp_level_o}, {31'b0, lvl});
    check(rsp_pa_o == pa, {tag, " pa"}, rsp_pa_o, pa);
    check(rsp_va_o == va, "R10 va echo", rsp_va_o, va);
    check(rd_n == int'(nrd), "R9 reads", rd_n, {30'b0, nrd});
    check(rd_addr[0] == (32'h0010_0000 | {18'b0, va[31:20], 2'b00}), "R2 l1 addr",
          rd_addr[0], 32'h0010_0000 | {18'b0, va[31:20], 2'b00});
    if (nrd == 2'd2)
      check(rd_addr[1] == (32'h0020_0400 | {22'b0, va[19:12], 2'b00}), "R4 l2 addr",
            rd_addr[1], 32'h0020_0400 | {22'b0, va[19:12], 2'b00});
    @(negedge clk_i);
    check(!rsp_valid_o, "R10 pulse", {31'b0, rsp_valid_o}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1 reset ready", {31'b0, req_ready_o}, 32'h1);
    check(rsp_valid_o == 1'b0, "R10 reset rsp", {31'b0, rsp_valid_o}, 32'h0);
    check(mem_req_valid_o == 1'b0, "R9 reset mem", {31'b0, mem_req_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    end
    stall = 0;

    // R1: request held while busy is taken only after the first response
    rd_n = 0;
    req_valid_i = 1'b1;
    req_va_i = 32'h0012_3456;
    @(negedge clk_i);
    req_va_i = 32'h0020_6DEF;
    while (!rsp_valid_o) @(negedge clk_i);
    check(rsp_va_o == 32'h0012_3456, "R1 first va", rsp_va_o, 32'h0012_3456);
    check(rsp_pa_o == 32'hABC2_3456, "R1 first pa", rsp_pa_o, 32'hABC2_3456);
    @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    check(rsp_va_o == 32'h0020_6DEF, "R1 second va", rsp_va_o, 32'h0020_6DEF);
    check(rsp_pa_o == 32'h5678_9DEF, "R6 second pa", rsp_pa_o, 32'h5678_9DEF);
    @(negedge clk_i);

    // R2: base low bits cleared gives the same walk
    ttb_i = 32'h0010_0000;
    run_vec(VEC[0]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule